// File: doc/BRIEF.md
# Single-Wire Bus Slave Command Sequencer

This block is the command layer of a slave on a single-wire, open-drain bus. A slot timing front end sits beside it and turns bus waveforms into one-cycle events: a write bit with its value, or the start of a read slot. The sequencer answers each read slot with the bit to put on the line, where 1 means the line is released. It also watches a sampled copy of the line. When the line stays low for a programmable number of clock cycles, the sequencer restarts and raises a presence pulse once the line comes back high.

After each bus reset, the master must send the transaction in a fixed order. First comes an 8-bit identity-layer command, then an 8-bit function command, then whatever data that function needs. The slave holds a 64-bit identity code. Through that code the master can read it, address it, or find it among other slaves with a bit-by-bit search. Function commands start a conversion, a copy or a recall, or they stream bits to or from a scratchpad. All of these are single-cycle strobes to logic outside the block. The slave also reports busy/done status and its power source through read slots.

Top module: `owr_slave_ctrl`

## Requirements
- R1: A bus reset happens when `line_low` is high for `RST_TICKS` consecutive cycles, and it is counted once per low period. A shorter low period has no effect. `presence` pulses for one cycle, one cycle after the line is released following a reset.
- R2: Each command byte arrives least significant bit first. The first byte after a reset must be an identity command. Any other first byte, including a function opcode, makes the slave ignore all traffic until the next reset.
- R3: The identity code is {CRC byte in bits 63:56, 48-bit serial in bits 55:8, family 8'h10 in bits 7:0}. The CRC uses x^8+x^5+x^4+1 over bits 0..55, least significant bit first, starting from zero. After command 8'h33, 64 read slots return the code from bit 0 upward, and then a function command is accepted.
- R4: After command 8'h55, the slave takes 64 write bits. If all of them equal its code, a function command is accepted. A single differing bit makes it ignore everything until reset.
- R5: Command 8'hCC goes straight to function command decoding.
- R6: Command 8'hF0 runs 64 triples. In each triple, a read slot returns the code bit, the next read slot returns its complement, and then a write bit is taken. If the written bit differs from the code bit, the slave drops out, and its later read slots return 1.
- R7: Command 8'hEC behaves as in R6 while `alarm_flag` is 1. When `alarm_flag` is 0, the slave stays silent (read slots return 1) until reset.
- R8: Function 8'h44 pulses `start_conv` and function 8'hB8 pulses `start_recall`. After either one, each read slot returns the inverse of `op_busy`.
- R9: Function 8'h48 pulses `start_copy`. At most one of the three start strobes is ever high at a time.
- R10: After function 8'h4E, each write bit produces one `sp_wr_stb` pulse with `sp_wr_bit` equal to that bit.
- R11: After function 8'hBE, each read slot returns `sp_rd_bit` and pulses `sp_rd_adv` once.
- R12: After function 8'hB4, each read slot returns 0 if `parasite` is 1, and 1 otherwise.
- R13: Out of power-on reset, the slave waits for a bus reset and ignores traffic until then. An unknown function opcode makes it ignore traffic until reset. In every ignoring state, read slots return 1.
- R14: Once a search of R6 or R7 finishes all 64 triples, nothing is accepted until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_low | input | 1 | Sampled bus level, 1 while the line is low |
| wr_stb | input | 1 | One-cycle event: master wrote a bit |
| wr_bit | input | 1 | Value of the written bit |
| rd_stb | input | 1 | One-cycle event: read slot started |
| alarm_flag | input | 1 | Alarm condition, gates the alarm search |
| op_busy | input | 1 | Conversion or recall in progress |
| parasite | input | 1 | 1 when the slave runs from line power |
| sp_rd_bit | input | 1 | Next scratchpad bit to send |
| presence | output | 1 | One-cycle presence request after a bus reset |
| rd_bit | output | 1 | Bit to drive in the current read slot (1 = release) |
| start_conv | output | 1 | Conversion start strobe |
| start_copy | output | 1 | Copy-to-nonvolatile strobe |
| start_recall | output | 1 | Recall strobe |
| sp_wr_stb | output | 1 | Scratchpad write bit strobe |
| sp_wr_bit | output | 1 | Scratchpad write bit value |
| sp_rd_adv | output | 1 | Scratchpad read pointer advance |

## Verification
The bench checks that a function opcode sent as the first byte is refused; a design that skipped the ordering rule would start a conversion. It flips one bit deep in a match sequence and drops out of a search midway. Both catch a slave that compares only part of the code or keeps answering after losing. The bench repeats a command after a completed search, and it sends a short low pulse that must not reset anything. These catch a design that forgets to lock out or that resets too eagerly. The alarm search is run with the flag clear, so that a slave ignoring the flag would pull the line low on the first slot.

// File: rtl/owr_pkg.sv
package owr_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_ROMCMD, ST_SENDID, ST_MATCHID, ST_SEARCH,
    ST_FUNCMD, ST_STATUS, ST_POWER, ST_SPWRITE, ST_SPREAD, ST_HALT
  } seq_state_t;

  localparam logic [7:0] OP_SEARCH  = 8'hF0;
  localparam logic [7:0] OP_READID  = 8'h33;
  localparam logic [7:0] OP_MATCH   = 8'h55;
  localparam logic [7:0] OP_SKIP    = 8'hCC;
  localparam logic [7:0] OP_ASEARCH = 8'hEC;
  localparam logic [7:0] OP_CONVERT = 8'h44;
  localparam logic [7:0] OP_SPWR    = 8'h4E;
  localparam logic [7:0] OP_SPRD    = 8'hBE;
  localparam logic [7:0] OP_COPY    = 8'h48;
  localparam logic [7:0] OP_RECALL  = 8'hB8;
  localparam logic [7:0] OP_PWR     = 8'hB4;

  // Reflected CRC-8 (x^8+x^5+x^4+1), zero start, data taken bit 0 first.
  function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] build_id(input logic [47:0] serial,
                                           input logic [7:0] family);
    logic [55:0] body;
    body = {serial, family};
    return {crc8_lsb(body), body};
  endfunction

endpackage

// File: rtl/owr_reset_det.sv
module owr_reset_det #(
  parameter int RST_TICKS = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low,
  output logic bus_rst,
  output logic presence
);
  localparam int CW = $clog2(RST_TICKS + 1);

  logic [CW-1:0] low_cnt;
  logic          armed;

  assign bus_rst = line_low && (low_cnt == CW'(RST_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      armed    <= 1'b0;
      presence <= 1'b0;
    end else begin
      presence <= 1'b0;
      if (line_low) begin
        if (low_cnt != CW'(RST_TICKS)) low_cnt <= low_cnt + 1'b1;
        if (bus_rst) armed <= 1'b1;
      end else begin
        low_cnt <= '0;
        if (armed) begin
          presence <= 1'b1;
          armed    <= 1'b0;
        end
      end
    end
  end

  a_r1_presence_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    presence |-> !$past(line_low));
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !bus_rst);

endmodule

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] next_word,
  output logic         last
);
  localparam int CW = $clog2(W) + 1;

  logic [W-2:0]  q;
  logic [CW-1:0] cnt;

  assign next_word = {bit_in, q};
  assign last      = (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      q   <= next_word[W-1:1];
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/owr_id_unit.sv
module owr_id_unit #(
  parameter logic [47:0] SERIAL = 48'h0,
  parameter logic [7:0]  FAMILY = 8'h10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic id_bit,
  output logic id_last
);
  localparam int ID_W = 64;
  localparam int IW   = $clog2(ID_W);
  localparam logic [ID_W-1:0] ID = owr_pkg::build_id(SERIAL, FAMILY);

  logic [IW-1:0] idx;

  assign id_bit  = ID[idx];
  assign id_last = (idx == IW'(ID_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (adv)  idx <= idx + 1'b1;
  end

  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));

endmodule

// File: rtl/owr_slave_ctrl.sv
module owr_slave_ctrl
  import owr_pkg::*;
#(
  parameter int          RST_TICKS = 24000,
  parameter logic [47:0] SERIAL    = 48'h0000_1A2B_3C4D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic rd_stb,
  input  logic alarm_flag,
  input  logic op_busy,
  input  logic parasite,
  input  logic sp_rd_bit,
  output logic presence,
  output logic rd_bit,
  output logic start_conv,
  output logic start_copy,
  output logic start_recall,
  output logic sp_wr_stb,
  output logic sp_wr_bit,
  output logic sp_rd_adv
);
  localparam int CMD_W = 8;

  seq_state_t       st;
  logic [1:0]       tri_ph;
  logic             bus_rst;
  logic             sh_en;
  logic [CMD_W-1:0] cmd_word;
  logic             cmd_last;
  logic             id_adv;
  logic             id_bit;
  logic             id_last;
  logic             id_hit;

  owr_reset_det #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .line_low(line_low),
    .bus_rst(bus_rst), .presence(presence));

  assign sh_en = wr_stb && !bus_rst && (st == ST_ROMCMD || st == ST_FUNCMD);

  owr_cmd_shift #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .shift_en(sh_en),
    .bit_in(wr_bit), .next_word(cmd_word), .last(cmd_last));

  assign id_hit = (wr_bit == id_bit);
  assign id_adv = !bus_rst && (
      (st == ST_SENDID  && rd_stb) ||
      (st == ST_MATCHID && wr_stb && id_hit) ||
      (st == ST_SEARCH  && wr_stb && tri_ph == 2'd2 && id_hit));

  owr_id_unit #(.SERIAL(SERIAL), .FAMILY(8'h10)) u_id (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .adv(id_adv),
    .id_bit(id_bit), .id_last(id_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_WAIT;
      tri_ph       <= 2'd0;
      rd_bit       <= 1'b1;
      start_conv   <= 1'b0;
      start_copy   <= 1'b0;
      start_recall <= 1'b0;
      sp_wr_stb    <= 1'b0;
      sp_wr_bit    <= 1'b0;
      sp_rd_adv    <= 1'b0;
    end else begin
      start_conv   <= 1'b0;
      start_copy   <= 1'b0;
      start_recall <= 1'b0;
      sp_wr_stb    <= 1'b0;
      sp_rd_adv    <= 1'b0;
      if (bus_rst) begin
        st     <= ST_ROMCMD;
        tri_ph <= 2'd0;
        rd_bit <= 1'b1;
      end else begin
        if (rd_stb) rd_bit <= 1'b1;
        case (st)
          ST_ROMCMD: if (wr_stb && cmd_last) begin
            case (cmd_word)
              OP_READID:  st <= ST_SENDID;
              OP_MATCH:   st <= ST_MATCHID;
              OP_SKIP:    st <= ST_FUNCMD;
              OP_SEARCH:  st <= ST_SEARCH;
              OP_ASEARCH: st <= alarm_flag ? ST_SEARCH : ST_HALT;
              default:    st <= ST_HALT;
            endcase
          end
          ST_SENDID: if (rd_stb) begin
            rd_bit <= id_bit;
            if (id_last) st <= ST_FUNCMD;
          end
          ST_MATCHID: if (wr_stb) begin
            if (!id_hit)      st <= ST_HALT;
            else if (id_last) st <= ST_FUNCMD;
          end
          ST_SEARCH: begin
            if (rd_stb && tri_ph == 2'd0) begin
              rd_bit <= id_bit;
              tri_ph <= 2'd1;
            end else if (rd_stb && tri_ph == 2'd1) begin
              rd_bit <= ~id_bit;
              tri_ph <= 2'd2;
            end else if (wr_stb && tri_ph == 2'd2) begin
              tri_ph <= 2'd0;
              if (!id_hit || id_last) st <= ST_HALT;
            end
          end
          ST_FUNCMD: if (wr_stb && cmd_last) begin
            case (cmd_word)
              OP_CONVERT: begin start_conv   <= 1'b1; st <= ST_STATUS; end
              OP_RECALL:  begin start_recall <= 1'b1; st <= ST_STATUS; end
              OP_COPY:    begin start_copy   <= 1'b1; st <= ST_HALT;   end
              OP_SPWR:    st <= ST_SPWRITE;
              OP_SPRD:    st <= ST_SPREAD;
              OP_PWR:     st <= ST_POWER;
              default:    st <= ST_HALT;
            endcase
          end
          ST_STATUS: if (rd_stb) rd_bit <= ~op_busy;
          ST_POWER:  if (rd_stb) rd_bit <= ~parasite;
          ST_SPWRITE: if (wr_stb) begin
            sp_wr_stb <= 1'b1;
            sp_wr_bit <= wr_bit;
          end
          ST_SPREAD: if (rd_stb) begin
            rd_bit    <= sp_rd_bit;
            sp_rd_adv <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_reset_enters_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (st == ST_ROMCMD));
  a_r13_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bus_rst && (st == ST_HALT || st == ST_WAIT)) |=> rd_bit);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_conv, start_copy, start_recall}));
  a_r8_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STATUS && rd_stb && !bus_rst) |=> (rd_bit == !$past(op_busy)));
  a_r12_power_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POWER && rd_stb && !bus_rst) |=> (rd_bit == !$past(parasite)));
  a_r10_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_stb |-> ($past(wr_stb) && sp_wr_bit == $past(wr_bit)));
  a_r11_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sp_rd_adv |-> ($past(rd_stb) && rd_bit == $past(sp_rd_bit)));

endmodule

// File: tb/tb_owr_slave_ctrl.sv
module tb_owr_slave_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          RT         = 16;
  localparam logic [47:0] SER        = 48'h3C5A_0F96_E1B7;
  localparam int          NV         = 11;
  // {expected read bit, expected strobes {recall,copy,conv}, {sp_rd_bit,parasite,busy}, opcode}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 3'b001, 3'b001, 8'h44},
    {1'b1, 3'b001, 3'b000, 8'h44},
    {1'b0, 3'b100, 3'b001, 8'hB8},
    {1'b1, 3'b100, 3'b000, 8'hB8},
    {1'b1, 3'b010, 3'b000, 8'h48},
    {1'b0, 3'b000, 3'b010, 8'hB4},
    {1'b1, 3'b000, 3'b000, 8'hB4},
    {1'b0, 3'b000, 3'b000, 8'hBE},
    {1'b1, 3'b000, 3'b100, 8'hBE},
    {1'b1, 3'b000, 3'b000, 8'hA5},
    {1'b1, 3'b000, 3'b000, 8'h4E}
  };

  logic clk = 0, rst_n = 0, line_low = 0, wr_stb = 0, wr_bit = 0, rd_stb = 0;
  logic alarm_flag = 0, op_busy = 0, parasite = 0, sp_rd_bit = 0;
  logic presence, rd_bit, start_conv, start_copy, start_recall;
  logic sp_wr_stb, sp_wr_bit, sp_rd_adv;

  owr_slave_ctrl #(.RST_TICKS(RT), .SERIAL(SER)) dut (
    .clk(clk), .rst_n(rst_n), .line_low(line_low), .wr_stb(wr_stb),
    .wr_bit(wr_bit), .rd_stb(rd_stb), .alarm_flag(alarm_flag),
    .op_busy(op_busy), .parasite(parasite), .sp_rd_bit(sp_rd_bit),
    .presence(presence), .rd_bit(rd_bit), .start_conv(start_conv),
    .start_copy(start_copy), .start_recall(start_recall),
    .sp_wr_stb(sp_wr_stb), .sp_wr_bit(sp_wr_bit), .sp_rd_adv(sp_rd_adv));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0, wr_cnt = 0, adv_cnt = 0;
  logic [2:0]  seen = 0;
  logic [7:0]  wr_log = 0;
  logic [63:0] exp_id;

  function automatic logic [63:0] make_id();
    logic [7:0]  r;
    logic [55:0] body;
    logic        inb;
    body = {SER, 8'h10};
    r = 8'h00;
    for (int i = 0; i < 56; i++) begin
      inb = body[i] ^ r[0];
      r = {inb, r[7], r[6], r[5], r[4] ^ inb, r[3] ^ inb, r[2], r[1]};
    end
    return {r, body};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic capture();
    if (start_conv)   seen[0] = 1'b1;
    if (start_copy)   seen[1] = 1'b1;
    if (start_recall) seen[2] = 1'b1;
    if (sp_wr_stb) begin wr_log = {wr_log[6:0], sp_wr_bit}; wr_cnt++; end
    if (sp_rd_adv) adv_cnt++;
  endtask

  task automatic wbit(input logic b);
    wr_stb = 1; wr_bit = b;
    @(negedge clk); wr_stb = 0; capture();
    @(negedge clk); capture();
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wbit(v[i]);
  endtask

  task automatic rbit(output logic b);
    rd_stb = 1;
    @(negedge clk); rd_stb = 0; b = rd_bit; capture();
    @(negedge clk); capture();
  endtask

  task automatic bus_reset(output logic pres);
    line_low = 1;
    repeat (RT + 3) @(negedge clk);
    line_low = 0;
    @(negedge clk); pres = presence;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h44, 8'hB8: return "R8";
      8'h48:        return "R9";
      8'hB4:        return "R12";
      8'hBE:        return "R11";
      8'h4E:        return "R10";
      default:      return "R13";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic p, a, b;
    int bad;
    exp_id = make_id();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "reset rd_bit", rd_bit, 1);
    chk("R13", "reset outputs", {presence, start_conv, start_copy, start_recall, sp_wr_stb, sp_rd_adv}, 0);

    // power-on: nothing accepted before first bus reset (R13)
    seen = 0; wbyte(8'hCC); wbyte(8'h44);
    chk("R13", "no conv before bus reset", seen, 0);

    // reset and presence (R1)
    bus_reset(p);
    chk("R1", "presence after reset", p, 1);
    wbyte(8'hCC);
    line_low = 1; repeat (RT - 4) @(negedge clk); line_low = 0;
    @(negedge clk);
    chk("R1", "no presence after short low", presence, 0);
    seen = 0; wbyte(8'h44);
    chk("R1", "short low kept transaction", seen, 3'b001);

    // out of order: function first (R2)
    bus_reset(p); seen = 0;
    wbyte(8'h44); wbyte(8'hCC); wbyte(8'h44);
    chk("R2", "function first refused", seen, 0);

    // skip (R5)
    bus_reset(p); seen = 0; wbyte(8'hCC); wbyte(8'h44);
    chk("R5", "skip then convert", seen, 3'b001);

    // read identity (R3)
    begin
      logic [63:0] got;
      bus_reset(p); wbyte(8'h33);
      for (int i = 0; i < 64; i++) begin rbit(a); got[i] = a; end
      chk("R3", "identity code", got, exp_id);
      seen = 0; wbyte(8'h44);
      chk("R3", "function after code read", seen, 3'b001);
    end

    // match (R4)
    bus_reset(p); wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(exp_id[i]);
    seen = 0; wbyte(8'h44);
    chk("R4", "match accepted", seen, 3'b001);
    bus_reset(p); wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(i == 40 ? ~exp_id[i] : exp_id[i]);
    seen = 0; wbyte(8'h44);
    chk("R4", "mismatch refused", seen, 0);

    // full search then lockout (R6, R14)
    bus_reset(p); wbyte(8'hF0); bad = 0;
    for (int i = 0; i < 64; i++) begin
      rbit(a); rbit(b);
      if (a !== exp_id[i] || b !== ~exp_id[i]) bad++;
      wbit(exp_id[i]);
    end
    chk("R6", "search triples mismatches", bad, 0);
    seen = 0; wbyte(8'hCC); wbyte(8'h44);
    chk("R14", "locked after search", seen, 0);

    // search dropout (R6)
    bus_reset(p); wbyte(8'hF0);
    for (int i = 0; i < 5; i++) begin rbit(a); rbit(b); wbit(exp_id[i]); end
    rbit(a); rbit(b); wbit(~exp_id[5]);
    rbit(a); rbit(b);
    chk("R6", "dropped out reads", {a, b}, 2'b11);

    // alarm search (R7): family bit 0 is 0, so taking part reads 0 then 1
    alarm_flag = 0; bus_reset(p); wbyte(8'hEC);
    rbit(a); rbit(b);
    chk("R7", "alarm clear silent", {a, b}, 2'b11);
    alarm_flag = 1; bus_reset(p); wbyte(8'hEC);
    rbit(a); rbit(b);
    chk("R7", "alarm set joins", {a, b}, {exp_id[0], ~exp_id[0]});
    alarm_flag = 0;

    // scratchpad write (R10)
    bus_reset(p); wbyte(8'hCC); wbyte(8'h4E);
    wr_cnt = 0; wr_log = 0;
    wbit(1); wbit(0); wbit(1); wbit(1);
    chk("R10", "write strobes", wr_cnt, 4);
    chk("R10", "write bits", wr_log[3:0], 4'b1011);

    // scratchpad read advance (R11)
    bus_reset(p); wbyte(8'hCC); wbyte(8'hBE);
    adv_cnt = 0; rbit(a); rbit(a); rbit(a);
    chk("R11", "read advances", adv_cnt, 3);

    // function table
    for (int k = 0; k < NV; k++) begin
      op_busy = VEC[k][8]; parasite = VEC[k][9]; sp_rd_bit = VEC[k][10];
      bus_reset(p); wbyte(8'hCC);
      seen = 0; wbyte(VEC[k][7:0]);
      chk(req_of(VEC[k][7:0]), $sformatf("strobes op %h", VEC[k][7:0]), seen, VEC[k][13:11]);
      rbit(a);
      chk(req_of(VEC[k][7:0]), $sformatf("read op %h", VEC[k][7:0]), a, VEC[k][14]);
    end

    summary();
    $finish;
  end
endmodule